// File: doc/BRIEF.md
# Add/Subtract Status Flag Unit

This unit adds or subtracts two operands at an operand size chosen per operation: byte, half-word or full word. A carry or borrow input joins the operation. The unit returns the size-limited result and six status flags. These are carry, parity, nibble (auxiliary) carry, zero, sign and signed overflow.

An execution pipeline uses it as the flag-producing stage of its arithmetic path. The caller raises `in_valid` for one cycle with the operands. One clock later the result and flags appear on registered outputs, together with a one-cycle `out_valid` pulse. The outputs then hold their values until the next accepted operation.

Top module: `arith_flag_unit`

## Requirements
- R1: With `op_sub`=0 the result is `opa + opb + cin` truncated to the selected size. `flag_c` is the carry out of the top bit of that size.
- R2: With `op_sub`=1 the result is `opa - opb - cin` truncated to the selected size. `flag_c` is 1 exactly when a borrow is taken from beyond the top bit, that is when the unsigned `opa` is less than `opb + cin` at that size.
- R3: `flag_a` is the carry out of bit 3 for addition, and the borrow into bit 3 for subtraction. For subtraction this means the low nibble of `opa` is less than the low nibble of `opb` plus `cin`.
- R4: `flag_z` is 1 exactly when the size-limited result is zero.
- R5: `flag_p` is 1 when result bits 7..0 hold an even number of ones, at every size.
- R6: `flag_s` equals result bit 7, 15 or 31 for byte, half-word or word size.
- R7: `flag_o` is 1 when the carry into the sign bit differs from the carry out of it. This means signed overflow of the operation at the selected size.
- R8: `size` 2'b00 selects 8 bits, 2'b01 selects 16 bits, and 2'b10 and 2'b11 both select 32 bits. Result bits above the selected size are 0.
- R9: The outputs update on the clock edge that samples `in_valid`=1, and `out_valid` is high for exactly that following cycle. Without `in_valid`, `result` and all flags hold their values.
- R10: Synchronous active-high `rst` clears `out_valid`, `result` and all flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| size | input | 2 | Operand size select |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| cin | input | 1 | Carry-in (add) or borrow-in (subtract) |
| out_valid | output | 1 | One-cycle result strobe |
| result | output | 32 | Size-limited result, upper bits zero |
| flag_c | output | 1 | Carry / borrow flag |
| flag_p | output | 1 | Even parity of low result byte |
| flag_a | output | 1 | Nibble carry / borrow flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_o | output | 1 | Signed overflow flag |

## Verification
The embedded properties relate the registered flags to the registered result and size. They therefore assume that the size code sampled with an operation is the one that governs the held outputs, so `size` must be steady while `in_valid` is high. They also assume that `in_valid` is low during reset. The stimulus changes inputs only on falling edges and drops `in_valid` before reset is applied. It covers all four size codes, including the redundant word code, and mixes directed carry, borrow and sign-boundary operands with random operands of arbitrary upper bits.

// File: rtl/arith_flag_pkg.sv
package arith_flag_pkg;
  localparam int DATA_W = 32;
  localparam int NUM_LANES = 3;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } size_e;

  // lane 0: byte, lane 1: half-word, lane 2: full word
  function automatic int lane_width(input int idx);
    return (idx == 0) ? 8 : (idx == 1) ? 16 : DATA_W;
  endfunction

  function automatic logic [1:0] lane_of(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 2'd0;
      SZ_HALF: return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/arith_lane.sv
module arith_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b_eff,
  input  logic         c_eff,
  output logic [W-1:0] sum,
  output logic         c_top,
  output logic         c_sign
);
  logic [W:0] full;

  always_comb begin
    full   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    sum    = full[W-1:0];
    c_top  = full[W];
    // carry that entered the sign position
    c_sign = full[W-1] ^ a[W-1] ^ b_eff[W-1];
  end
endmodule

// File: rtl/arith_flag_pick.sv
module arith_flag_pick
  import arith_flag_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NL = NUM_LANES
) (
  input  logic [NL-1:0][DW-1:0] lane_sum,
  input  logic [NL-1:0]         lane_ctop,
  input  logic [NL-1:0]         lane_csign,
  input  logic [1:0]            lane_sel,
  input  logic                  nib_carry,
  input  logic                  is_sub,
  output logic [DW-1:0]         res,
  output logic                  fc,
  output logic                  fp,
  output logic                  fa,
  output logic                  fz,
  output logic                  fs,
  output logic                  fo
);
  always_comb begin
    res = lane_sum[lane_sel];
    fc  = lane_ctop[lane_sel] ^ is_sub;
    fo  = lane_ctop[lane_sel] ^ lane_csign[lane_sel];
    fa  = nib_carry ^ is_sub;
    fp  = ~^res[7:0];
    fz  = (res == '0);
    case (lane_sel)
      2'd0:    fs = res[7];
      2'd1:    fs = res[15];
      default: fs = res[DW-1];
    endcase
  end
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import arith_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              op_sub,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              cin,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              flag_c,
  output logic              flag_p,
  output logic              flag_a,
  output logic              flag_z,
  output logic              flag_s,
  output logic              flag_o
);
  logic [DATA_W-1:0] b_eff;
  logic              c_eff;
  logic [4:0]        nib;

  assign b_eff = op_sub ? ~opb : opb;
  assign c_eff = op_sub ? ~cin : cin;
  assign nib   = {1'b0, opa[3:0]} + {1'b0, b_eff[3:0]} + {4'b0, c_eff};

  logic [NUM_LANES-1:0][DATA_W-1:0] lane_sum;
  logic [NUM_LANES-1:0]             lane_ctop;
  logic [NUM_LANES-1:0]             lane_csign;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    localparam int LW = lane_width(i);
    logic [LW-1:0] s;
    arith_lane #(.W(LW)) u_lane (
      .a      (opa[LW-1:0]),
      .b_eff  (b_eff[LW-1:0]),
      .c_eff  (c_eff),
      .sum    (s),
      .c_top  (lane_ctop[i]),
      .c_sign (lane_csign[i])
    );
    if (LW < DATA_W) begin : g_pad
      assign lane_sum[i] = {{(DATA_W-LW){1'b0}}, s};
    end else begin : g_full
      assign lane_sum[i] = s;
    end
  end

  logic [DATA_W-1:0] res_d;
  logic fc_d, fp_d, fa_d, fz_d, fs_d, fo_d;

  arith_flag_pick #(.DW(DATA_W), .NL(NUM_LANES)) u_pick (
    .lane_sum   (lane_sum),
    .lane_ctop  (lane_ctop),
    .lane_csign (lane_csign),
    .lane_sel   (lane_of(size)),
    .nib_carry  (nib[4]),
    .is_sub     (op_sub),
    .res        (res_d),
    .fc         (fc_d),
    .fp         (fp_d),
    .fa         (fa_d),
    .fz         (fz_d),
    .fs         (fs_d),
    .fo         (fo_d)
  );

  logic [1:0] size_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      size_q    <= 2'b00;
      {flag_c, flag_p, flag_a, flag_z, flag_s, flag_o} <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res_d;
        size_q <= size;
        {flag_c, flag_p, flag_a, flag_z, flag_s, flag_o} <=
          {fc_d, fp_d, fa_d, fz_d, fs_d, fo_d};
      end
    end
  end

  // R9: a result strobe only follows an accepted operation
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));
  // R9: held outputs do not move without an operation
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_valid) && !$past(rst)) |-> $stable(result));
  // R4
  a_r4_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flag_z == (result == '0)));
  // R5
  a_r5_parity: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flag_p == ~^result[7:0]));
  // R6
  a_r6_sign: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flag_s == ((size_q == 2'b00) ? result[7] :
                              (size_q == 2'b01) ? result[15] : result[DATA_W-1])));
  // R8: upper bits of narrow results are clear
  a_r8_byte_upper: assert property (@(posedge clk) disable iff (rst)
    (out_valid && size_q == 2'b00) |-> (result[DATA_W-1:8] == '0));
  a_r8_half_upper: assert property (@(posedge clk) disable iff (rst)
    (out_valid && size_q == 2'b01) |-> (result[DATA_W-1:16] == '0));
endmodule

// File: tb/arith_flag_unit_bench.sv
module arith_flag_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        op_sub = 1'b0;
  logic [1:0]  size = 2'b00;
  logic [31:0] opa = '0, opb = '0;
  logic        cin = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_c, flag_p, flag_a, flag_z, flag_s, flag_o;

  always #5 clk = ~clk;

  arith_flag_unit u_arith_flag_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub), .size(size),
    .opa(opa), .opb(opb), .cin(cin), .out_valid(out_valid), .result(result),
    .flag_c(flag_c), .flag_p(flag_p), .flag_a(flag_a), .flag_z(flag_z),
    .flag_s(flag_s), .flag_o(flag_o)
  );

  typedef struct {
    logic [31:0] res;
    logic c, p, a, z, s, o;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails = 0;
  logic        have_last = 1'b0;
  exp_t        last_exp;
  logic        done = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference model built from the requirements
  function automatic exp_t model(input logic sub, input logic [1:0] sz,
                                 input logic [31:0] a, input logic [31:0] b,
                                 input logic ci);
    exp_t e;
    int w;
    longint unsigned mask, am, bm, full;
    logic sa, sb, sr;
    w    = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;      // R8
    mask = (64'd1 << w) - 1;
    am   = a & mask;
    bm   = b & mask;
    if (!sub) begin
      full = am + bm + ci;                                    // R1
      e.c  = full[w];
      e.a  = ((a & 15) + (b & 15) + ci) > 15;                 // R3
    end else begin
      full = am - bm - ci;                                    // R2
      e.c  = am < (bm + ci);
      e.a  = (a & 15) < ((b & 15) + ci);
    end
    e.res = 32'(full & mask);
    sa = am[w-1]; sb = bm[w-1]; sr = e.res[w-1];
    e.o = sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa)); // R7
    e.s = sr;                                                 // R6
    e.z = (e.res == 0);                                       // R4
    e.p = ~^e.res[7:0];                                       // R5
    return e;
  endfunction

  task automatic drive(input logic sub, input logic [1:0] sz,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic ci);
    @(negedge clk);
    in_valid = 1'b1; op_sub = sub; size = sz; opa = a; opb = b; cin = ci;
    exp_q.push_back(model(sub, sz, a, b, ci));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor/scoreboard, sampled on falling edges
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check("R9", "unexpected out_valid", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check("R1/R2/R8", "result", result, e.res);
          check("R1/R2", "flag_c", {31'b0, flag_c}, {31'b0, e.c});
          check("R3", "flag_a", {31'b0, flag_a}, {31'b0, e.a});
          check("R4", "flag_z", {31'b0, flag_z}, {31'b0, e.z});
          check("R5", "flag_p", {31'b0, flag_p}, {31'b0, e.p});
          check("R6", "flag_s", {31'b0, flag_s}, {31'b0, e.s});
          check("R7", "flag_o", {31'b0, flag_o}, {31'b0, e.o});
          last_exp  = e;
          have_last = 1'b1;
        end
      end else if (have_last) begin
        // R9: outputs hold between operations
        check("R9", "held result", result, last_exp.res);
        check("R9", "held flags", {26'b0, flag_c, flag_p, flag_a, flag_z, flag_s, flag_o},
              {26'b0, last_exp.c, last_exp.p, last_exp.a, last_exp.z, last_exp.s, last_exp.o});
      end
    end
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check("R10", "out_valid after reset", {31'b0, out_valid}, 32'd0);
    check("R10", "result after reset", result, 32'd0);
    check("R10", "flags after reset", {26'b0, flag_c, flag_p, flag_a, flag_z, flag_s, flag_o}, 32'd0);

    drive(1'b0, 2'b00, 32'h0000_00FF, 32'h0000_0001, 1'b0); // R1 byte wrap to zero
    drive(1'b0, 2'b00, 32'h0000_007F, 32'h0000_0001, 1'b0); // R7 byte overflow
    drive(1'b1, 2'b00, 32'h0000_0000, 32'h0000_0001, 1'b0); // R2 byte borrow
    drive(1'b1, 2'b01, 32'h0000_8000, 32'h0000_0001, 1'b0); // R7 half sub overflow
    drive(1'b0, 2'b10, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1); // R1 word carry via cin
    drive(1'b0, 2'b11, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0); // R8 alt word code
    drive(1'b0, 2'b00, 32'h1234_56FF, 32'hABCD_EF01, 1'b0); // R8 upper bits ignored
    drive(1'b1, 2'b01, 32'h0001_0010, 32'h0000_0001, 1'b1); // R3 nibble borrow, R2 borrow-in
    drive(1'b1, 2'b10, 32'h0000_0005, 32'h0000_0005, 1'b0); // R4 zero on sub
    drive(1'b0, 2'b01, 32'h0000_0008, 32'h0000_0008, 1'b0); // R3 nibble carry
    repeat (3) @(negedge clk);                               // R9 hold window

    // back-to-back random traffic
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      op_sub = 1'($urandom); size = 2'($urandom);
      opa = $urandom; opb = $urandom; cin = 1'($urandom);
      exp_q.push_back(model(op_sub, size, opa, opb, cin));
      if (i % 7 == 0) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R9", "queue drained", exp_q.size(), 32'd0);

    // R10: reset mid-run clears outputs
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    have_last = 1'b0;
    @(negedge clk);
    check("R10", "result after second reset", result, 32'd0);
    check("R10", "out_valid after second reset", {31'b0, out_valid}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule